// File: doc/BRIEF.md
# Three-Stage JK Pulse-Train Generator

This block produces a repeating serial pulse train from three JK flip-flops that share one clock. The JK inputs of each stage are wired to fixed excitation terms, so the state walks a short loop of four codes. The loop is chosen so that its least significant bit is itself the wanted waveform, and no decoder follows the state. The bit pattern is low for one clock and then high for three.

The generator has only a clock and an active-high synchronous reset. It presents both the full state word and the single serial bit. The four codes outside the loop each lead back into it after one clock edge. A stray state therefore heals itself without a reset. The value that reset loads is a parameter, which defaults to zero.

Top module: `jk_seq_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state loads `INIT_STATE` (default 3'b000) on that edge.
- R2: Each stage is a JK flip-flop. With J,K = 0,0 it holds, 0,1 clears, 1,0 sets and 1,1 toggles.
- R3: Starting from 000, the state (bit 2 down to bit 0) steps 001, 011, 101 and back to 000, one step per clock, with period four.
- R4: `ser_o` equals bit 0 of the state. After a reset to 000 it shows 0 and then 1, 1, 1, repeating.
- R5: The excitation terms are as follows. Bit 2 takes J = bit 1 and K = 1. Bit 1 takes J = (not bit 2) and bit 0, with K = 1. Bit 0 takes J = 1 and K = bit 2.
- R6: The unused codes rejoin the loop on the first edge. 010 goes to 101, 100 goes to 001, 110 goes to 001 and 111 goes to 000.
- R7: Raising `rst` in the middle of the loop overrides the excitation terms and returns the state to `INIT_STATE` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all stages |
| rst | input | 1 | Synchronous reset, active high |
| state_o | output | 3 | Registered state word, bit 0 is the pulse stage |
| ser_o | output | 1 | Serial pulse-train bit (state bit 0) |

## Verification
The clock and reset cannot steer the state into an unused code. The bench therefore builds one instance with the default `INIT_STATE` of 000 and four more with `INIT_STATE` set to 010, 100, 110 and 111. The default instance covers the main loop, the serial pattern and a reset applied mid-loop. The other four bring each unused code within reach for one edge after reset is released. This checks the recovery target of each code and the path that follows it into the loop.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;
  localparam int STAGES = 3;
  typedef logic [STAGES-1:0] state_t;

  localparam state_t ST_A = 3'b000;
  localparam state_t ST_B = 3'b001;
  localparam state_t ST_C = 3'b011;
  localparam state_t ST_D = 3'b101;
endpackage

// File: rtl/jk_stage.sv
module jk_stage #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else begin
      unique case ({j, k})
        2'b00:   q <= q;
        2'b01:   q <= 1'b0;
        2'b10:   q <= 1'b1;
        default: q <= ~q;
      endcase
    end
  end

  AST_JK_SET:    assert property (@(posedge clk) disable iff (rst) (j && !k) |=> q);             // R2
  AST_JK_CLEAR:  assert property (@(posedge clk) disable iff (rst) (!j && k) |=> !q);            // R2
  AST_JK_TOGGLE: assert property (@(posedge clk) disable iff (rst) (j && k) |=> (q != $past(q))); // R2
  AST_JK_HOLD:   assert property (@(posedge clk) disable iff (rst) (!j && !k) |=> $stable(q));   // R2
endmodule

// File: rtl/seqgen_excite.sv
module seqgen_excite
  import seqgen_pkg::*;
(
  input  state_t q,
  output state_t j,
  output state_t k
);
  // stage 2 (top), stage 1 (middle), stage 0 (pulse bit)
  always_comb begin
    j[2] = q[1];
    k[2] = 1'b1;
    j[1] = ~q[2] & q[0];
    k[1] = 1'b1;
    j[0] = 1'b1;
    k[0] = q[2];
  end
endmodule

// File: rtl/jk_seq_gen.sv
module jk_seq_gen
  import seqgen_pkg::*;
#(
  parameter logic [2:0] INIT_STATE = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] state_o,
  output logic       ser_o
);
  localparam int NUM_STAGES = STAGES;

  state_t q_v;
  state_t j_v;
  state_t k_v;

  seqgen_excite u_excite (
    .q (q_v),
    .j (j_v),
    .k (k_v)
  );

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    jk_stage #(.RST_VAL(INIT_STATE[g])) u_ff (
      .clk (clk),
      .rst (rst),
      .j   (j_v[g]),
      .k   (k_v[g]),
      .q   (q_v[g])
    );
  end

  assign state_o = q_v;
  assign ser_o   = q_v[0];

  logic in_loop;
  assign in_loop = (state_o == ST_A) || (state_o == ST_B) ||
                   (state_o == ST_C) || (state_o == ST_D);

  AST_RESET_LOAD:  assert property (@(posedge clk) rst |=> (state_o == INIT_STATE));                         // R1
  AST_STEP_A:      assert property (@(posedge clk) disable iff (rst) (state_o == ST_A) |=> (state_o == ST_B)); // R3
  AST_STEP_B:      assert property (@(posedge clk) disable iff (rst) (state_o == ST_B) |=> (state_o == ST_C)); // R3
  AST_STEP_C:      assert property (@(posedge clk) disable iff (rst) (state_o == ST_C) |=> (state_o == ST_D)); // R3
  AST_STEP_D:      assert property (@(posedge clk) disable iff (rst) (state_o == ST_D) |=> (state_o == ST_A)); // R3
  AST_LOW_AFTER_D: assert property (@(posedge clk) disable iff (rst) (state_o == ST_D) |=> !ser_o);           // R4
  AST_RECOVER:     assert property (@(posedge clk) disable iff (rst) !in_loop |=> in_loop);                   // R6
endmodule

// File: tb/tb_jk_seq_gen.sv
module tb_jk_seq_gen;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [2:0] st0, st2, st4, st6, st7;
  logic       ser0, ser2, ser4, ser6, ser7;

  always #(CLK_P/2) clk = ~clk;

  jk_seq_gen #(.INIT_STATE(3'b000)) dut    (.clk(clk), .rst(rst), .state_o(st0), .ser_o(ser0));
  jk_seq_gen #(.INIT_STATE(3'b010)) dut_s2 (.clk(clk), .rst(rst), .state_o(st2), .ser_o(ser2));
  jk_seq_gen #(.INIT_STATE(3'b100)) dut_s4 (.clk(clk), .rst(rst), .state_o(st4), .ser_o(ser4));
  jk_seq_gen #(.INIT_STATE(3'b110)) dut_s6 (.clk(clk), .rst(rst), .state_o(st6), .ser_o(ser6));
  jk_seq_gen #(.INIT_STATE(3'b111)) dut_s7 (.clk(clk), .rst(rst), .state_o(st7), .ser_o(ser7));

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    step();
    step();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst = 1'b1;
    step();
    chk("R1 init 000", st0, 3'b000);
    chk("R1 init 010", st2, 3'b010);
    chk("R1 init 100", st4, 3'b100);
    chk("R1 init 110", st6, 3'b110);
    chk("R1 init 111", st7, 3'b111);
    chk("R4 ser at reset", {2'b00, ser0}, 3'b000);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_main_loop();
    logic [2:0] exp_s [4] = '{3'b001, 3'b011, 3'b101, 3'b000};
    apply_reset();
    for (int i = 0; i < 12; i++) begin
      step();
      chk("R3 R5 loop state", st0, exp_s[i % 4]);
      chk("R4 serial bit", {2'b00, ser0}, {2'b00, exp_s[i % 4][0]});
    end
  endtask

  task automatic t_recovery();
    apply_reset();
    step();
    chk("R6 R2 010 to 101", st2, 3'b101);
    chk("R6 R5 100 to 001", st4, 3'b001);
    chk("R6 R5 110 to 001", st6, 3'b001);
    chk("R6 R2 111 to 000", st7, 3'b000);
    step();
    chk("R6 follow 101 to 000", st2, 3'b000);
    chk("R6 follow 001 to 011", st4, 3'b011);
    chk("R6 follow 001 to 011", st6, 3'b011);
    chk("R6 follow 000 to 001", st7, 3'b001);
  endtask

  task automatic t_mid_reset();
    apply_reset();
    step();
    step();
    chk("R7 precondition 011", st0, 3'b011);
    @(negedge clk);
    rst = 1'b1;
    step();
    chk("R7 reset mid loop", st0, 3'b000);
    chk("R7 unused init reloaded", st6, 3'b110);
    @(negedge clk);
    rst = 1'b0;
    step();
    chk("R7 restart 001", st0, 3'b001);
  endtask

  initial begin
    t_reset_state();
    t_main_loop();
    t_recovery();
    t_mid_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 5000);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule